// File: doc/BRIEF.md
# Two-Channel Cascaded Clock Divider

This block divides one fast input clock into two slower output clocks. Each channel passes the input clock through two cascaded stages. The first is a small prescaler with ratios 2 to 6. The second is an output divider with ratios 1 to 32. Together they give an overall ratio from 2 to 192. Each output has equal high and low times for every ratio, odd ratios included. Odd ratios use a half-cycle retimed copy of the count, taken on the falling edge of the input clock.

Each channel has one 8-bit divide register. A pair-level sync bit makes the second channel take its prescaler from the first channel. With one shared prescaler, both outputs keep a fixed phase relation, and their rising edges line up when one overall ratio is a whole multiple of the other. Each channel also has a power-down input, which holds that channel's counters cleared and its output low.

A write to a divide register, a write to the sync bit, or a power-up of a channel restarts the affected counters. A new setting therefore always starts from a clean edge.

Top module: `clk_div_pair`

## Requirements
- R1: Bits [7:5] of a channel's divide register pick the prescaler ratio. Codes 2 to 6 give that ratio, codes 0 and 1 give 2, and code 7 gives 6.
- R2: Bits [4:0] of the same register pick the output divider ratio. Code 0 gives 32 and any other code gives its binary value.
- R3: The output period, counted in input clock cycles, equals the prescaler ratio times the output divider ratio.
- R4: For an overall ratio N, the output is high for exactly N half-periods of the input clock and low for exactly N half-periods, whether N is odd or even.
- R5: While the sync bit (bit 0 of the sync write data) is 1, channel 1 uses channel 0's prescaler ratio and count, and ignores its own prescaler code. In this mode each rising edge of channel 1 falls on a rising edge of channel 0 when channel 1's ratio is a multiple of channel 0's ratio and both are even. When the sync bit is cleared, channel 1 returns to its own prescaler.
- R6: While a channel's power-down input is 1, its output is low from the first rising clock edge that samples it, and the other channel keeps running. When the input returns to 0, the counters restart. For an even ratio, the output is low after the first edge that samples power-down low and goes high on the next rising edge.
- R7: A divide register write clears that channel's counters on the edge that samples it. For an even ratio, the output is low after that edge and goes high on the next rising edge.
- R8: While rst_ni is low, both outputs are low. After reset both divide registers hold 8'h41 (ratio 2 × 1) and the sync bit is 0, so both outputs run at half the input clock.
- R9: While the sync bit is 1, a write to either divide register, or a power-up of either channel, restarts both channels and the shared prescaler on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 2 | Write strobe for each channel's divide register |
| div_wdata_i | input | 8 | Divide register data: [7:5] prescaler code, [4:0] output divider code |
| sync_we_i | input | 1 | Write strobe for the sync bit |
| sync_wdata_i | input | 1 | New sync bit value |
| pd_i | input | 2 | Power-down for each channel, active high |
| clk_o | output | 2 | Divided output clocks, one per channel |

## Verification
The hardest case to reach is the phase relation between the two channels under a shared prescaler. It only shows up once a channel pair is set to related ratios and restarted together. It is also masked if the two channels' own prescaler codes happen to match. The stimulus therefore gives channel 1 a prescaler code that differs from channel 0's, turns sync on, and then watches every half-cycle for a channel 1 rising edge that does not land on a channel 0 rising edge. It then rewrites channel 1 alone and checks that channel 0 restarted on the same edge.

// File: rtl/clk_div_pair_pkg.sv
`timescale 1ns/1ps
package clk_div_pair_pkg;
  localparam int NUM_CH       = 2;
  localparam int PRE_CODE_W   = 3;
  localparam int POST_CODE_W  = 5;
  localparam int REG_W        = PRE_CODE_W + POST_CODE_W;
  localparam int PRE_MIN      = 2;
  localparam int PRE_MAX      = 6;
  localparam int POST_MAX     = 32;
  localparam int PRE_CNT_W    = $clog2(PRE_MAX + 1);
  localparam int POST_CNT_W   = $clog2(POST_MAX);
  localparam int POST_RATIO_W = $clog2(POST_MAX + 1);
  localparam int RATIO_W      = $clog2(PRE_MAX * POST_MAX + 1);

  function automatic logic [PRE_CNT_W-1:0] pre_decode(input logic [PRE_CODE_W-1:0] code);
    if (code < PRE_CODE_W'(PRE_MIN))      return PRE_CNT_W'(PRE_MIN);
    else if (code > PRE_CODE_W'(PRE_MAX)) return PRE_CNT_W'(PRE_MAX);
    else                                  return PRE_CNT_W'(code);
  endfunction

  function automatic logic [POST_RATIO_W-1:0] post_decode(input logic [POST_CODE_W-1:0] code);
    return (code == '0) ? POST_RATIO_W'(POST_MAX) : POST_RATIO_W'(code);
  endfunction
endpackage

// File: rtl/clk_div_prescaler.sv
`timescale 1ns/1ps
module clk_div_prescaler
  import clk_div_pair_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic                 clr_i,
  input  logic [PRE_CNT_W-1:0] ratio_i,
  output logic [PRE_CNT_W-1:0] cnt_o,
  output logic                 tick_o
);
  logic [PRE_CNT_W-1:0] cnt_q;
  logic [PRE_CNT_W-1:0] last;

  assign last   = ratio_i - PRE_CNT_W'(1);
  assign cnt_o  = cnt_q;
  assign tick_o = run_i && !clr_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else if (cnt_q == last)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + PRE_CNT_W'(1);
  end

  assert_pre_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_i);
endmodule

// File: rtl/clk_div_channel.sv
`timescale 1ns/1ps
module clk_div_channel
  import clk_div_pair_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    clr_i,
  input  logic [PRE_CNT_W-1:0]    pre_ratio_i,
  input  logic [PRE_CNT_W-1:0]    pre_cnt_i,
  input  logic                    tick_i,
  input  logic [POST_RATIO_W-1:0] post_ratio_i,
  output logic                    clk_o
);
  logic [POST_CNT_W-1:0]   d_cnt_q;
  logic [POST_RATIO_W-1:0] d_last;
  logic [RATIO_W-1:0]      total, half, phase;
  logic                    q_pos, q_neg;

  assign d_last = post_ratio_i - POST_RATIO_W'(1);
  assign total  = RATIO_W'(pre_ratio_i) * RATIO_W'(post_ratio_i);
  assign half   = (total >> 1) + RATIO_W'(total[0]);
  // position inside the full output period
  assign phase  = RATIO_W'(d_cnt_q) * RATIO_W'(pre_ratio_i) + RATIO_W'(pre_cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_cnt_q <= '0;
      q_pos   <= 1'b0;
    end else if (clr_i || !run_i) begin
      d_cnt_q <= '0;
      q_pos   <= 1'b0;
    end else begin
      q_pos <= (phase < half);
      if (tick_i) begin
        if (POST_RATIO_W'(d_cnt_q) == d_last) d_cnt_q <= '0;
        else                                  d_cnt_q <= d_cnt_q + POST_CNT_W'(1);
      end
    end
  end

  // half-cycle retimed copy trims the high time for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_neg <= 1'b0;
    else         q_neg <= q_pos;
  end

  assign clk_o = total[0] ? (q_pos & q_neg) : q_pos;

  assert_post_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    POST_RATIO_W'(d_cnt_q) < post_ratio_i);
  assert_rise_at_phase_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_pos) |-> ($past(phase) == '0));
  assert_pd_holds_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !q_pos);
endmodule

// File: rtl/clk_div_pair.sv
`timescale 1ns/1ps
module clk_div_pair
  import clk_div_pair_pkg::*;
#(
  parameter logic [REG_W-1:0] DIV_RST = 8'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] div_we_i,
  input  logic [REG_W-1:0]  div_wdata_i,
  input  logic              sync_we_i,
  input  logic              sync_wdata_i,
  input  logic [NUM_CH-1:0] pd_i,
  output logic [NUM_CH-1:0] clk_o
);
  logic [NUM_CH-1:0][REG_W-1:0]        div_q;
  logic                                sync_q;
  logic [NUM_CH-1:0]                   pd_q, pwr_up, chg, clr, run_pre;
  logic [NUM_CH-1:0][PRE_CNT_W-1:0]    pre_ratio, pre_cnt, sel_ratio, sel_cnt;
  logic [NUM_CH-1:0]                   pre_tick, sel_tick;
  logic [NUM_CH-1:0][POST_RATIO_W-1:0] post_ratio;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= {NUM_CH{DIV_RST}};
      sync_q <= 1'b0;
      pd_q   <= '1;
    end else begin
      for (int k = 0; k < NUM_CH; k++)
        if (div_we_i[k]) div_q[k] <= div_wdata_i;
      if (sync_we_i) sync_q <= sync_wdata_i;
      pd_q <= pd_i;
    end
  end

  assign pwr_up = pd_q & ~pd_i;
  assign chg    = div_we_i | pwr_up;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign pre_ratio[k]  = pre_decode(div_q[k][REG_W-1:POST_CODE_W]);
    assign post_ratio[k] = post_decode(div_q[k][POST_CODE_W-1:0]);
    // under sync every change restarts the whole pair
    assign clr[k] = sync_we_i | chg[k] | (sync_q & (|chg));

    if (k == 0) begin : g_lead
      assign run_pre[k]   = ~pd_i[k] | (sync_q & (|(~pd_i)));
      assign sel_ratio[k] = pre_ratio[k];
      assign sel_cnt[k]   = pre_cnt[k];
      assign sel_tick[k]  = pre_tick[k];
    end else begin : g_follow
      assign run_pre[k]   = ~pd_i[k] & ~sync_q;
      assign sel_ratio[k] = sync_q ? pre_ratio[0] : pre_ratio[k];
      assign sel_cnt[k]   = sync_q ? pre_cnt[0]   : pre_cnt[k];
      assign sel_tick[k]  = sync_q ? pre_tick[0]  : pre_tick[k];
    end

    clk_div_prescaler u_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_pre[k]),
      .clr_i   (clr[k]),
      .ratio_i (pre_ratio[k]),
      .cnt_o   (pre_cnt[k]),
      .tick_o  (pre_tick[k])
    );

    clk_div_channel u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .run_i        (~pd_i[k]),
      .clr_i        (clr[k]),
      .pre_ratio_i  (sel_ratio[k]),
      .pre_cnt_i    (sel_cnt[k]),
      .tick_i       (sel_tick[k]),
      .post_ratio_i (post_ratio[k]),
      .clk_o        (clk_o[k])
    );

    always_comb begin
      assert_pre_decode_R1: assert (pre_ratio[k] >= PRE_CNT_W'(PRE_MIN) &&
                                    pre_ratio[k] <= PRE_CNT_W'(PRE_MAX));
      assert_post_decode_R2: assert (post_ratio[k] != '0 &&
                                     post_ratio[k] <= POST_RATIO_W'(POST_MAX));
    end

    assert_pd_out_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pd_i[k] |=> !clk_o[k]);
    assert_write_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_we_i[k] |=> !clk_o[k]);
  end

  assert_sync_pair_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && (|div_we_i)) |=> (clk_o == '0));
endmodule

// File: tb/clk_div_pair_tb.sv
`timescale 1ns/1ps
module clk_div_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int GUARD      = 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] div_we;
  logic [7:0] div_wdata;
  logic       sync_we, sync_wdata;
  logic [1:0] pd;
  logic [1:0] clk_out;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct { int ch; int halves; string req; } exp_t;
  exp_t sb_q[$];

  always #(HALF) clk = ~clk;

  clk_div_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .div_we_i(div_we), .div_wdata_i(div_wdata),
    .sync_we_i(sync_we), .sync_wdata_i(sync_wdata), .pd_i(pd), .clk_o(clk_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mid();
    @(posedge clk); #2;
  endtask

  task automatic write_div(input int ch, input logic [7:0] v);
    mid();
    div_we[ch] = 1'b1; div_wdata = v;
    mid();
    div_we = '0;
  endtask

  task automatic write_sync(input logic v);
    mid();
    sync_we = 1'b1; sync_wdata = v;
    mid();
    sync_we = 1'b0;
  endtask

  // driver side: queue the expected half-period count for a channel
  task automatic expect_ratio(input int ch, input int n, input string req);
    sb_q.push_back('{ch: ch, halves: n, req: req});
    monitor();
  endtask

  // monitor side: measure one high and one low run on a half-cycle grid
  task automatic monitor();
    exp_t e;
    int hi = 0, lo = 0, g = 0;
    e = sb_q.pop_front();
    mid();
    while (clk_out[e.ch] && g < GUARD) begin #(HALF); g++; end
    while (!clk_out[e.ch] && g < GUARD) begin #(HALF); g++; end
    while (clk_out[e.ch] && g < GUARD) begin hi++; #(HALF); g++; end
    while (!clk_out[e.ch] && g < GUARD) begin lo++; #(HALF); g++; end
    check(hi == e.halves, e.req, $sformatf("ch%0d high half-cycles", e.ch), hi, e.halves);
    check(lo == e.halves, e.req, $sformatf("ch%0d low half-cycles", e.ch), lo, e.halves);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int highs, rises, miss;
    logic p0, p1;
    rst_n = 1'b0; div_we = '0; div_wdata = '0; sync_we = 1'b0; sync_wdata = 1'b0; pd = '0;
    repeat (3) mid();
    check(clk_out == 2'b00, "R8", "outputs in reset", clk_out, 0);
    rst_n = 1'b1;
    expect_ratio(0, 2, "R8");
    expect_ratio(1, 2, "R8");

    // R7: restart timing on an even ratio (4*2)
    write_div(1, 8'b100_00010);
    check(clk_out[1] == 1'b0, "R7", "low after write edge", clk_out[1], 0);
    mid();
    check(clk_out[1] == 1'b1, "R7", "high one edge later", clk_out[1], 1);
    expect_ratio(1, 8, "R3");

    write_div(0, 8'b011_00011); expect_ratio(0, 9, "R4");   // odd 3*3
    write_div(0, 8'b101_00111); expect_ratio(0, 35, "R4");  // odd 5*7
    write_div(0, 8'b111_00001); expect_ratio(0, 6, "R1");   // code 7 clamps to 6
    write_div(0, 8'b000_00001); expect_ratio(0, 2, "R1");   // code 0 clamps to 2
    write_div(0, 8'b001_00101); expect_ratio(0, 10, "R1");  // code 1 clamps to 2
    write_div(1, 8'b010_00000); expect_ratio(1, 64, "R2");  // post code 0 -> 32
    write_div(1, 8'b110_11111); expect_ratio(1, 186, "R3"); // 6*31

    // R6: power-down of channel 1, channel 0 keeps running
    write_div(1, 8'b100_00010);
    mid(); pd[1] = 1'b1;
    mid();
    highs = 0;
    for (int i = 0; i < 40; i++) begin highs += clk_out[1]; #(HALF); end
    check(highs == 0, "R6", "ch1 high samples while down", highs, 0);
    expect_ratio(0, 10, "R6");
    mid(); pd[1] = 1'b0;
    mid();
    check(clk_out[1] == 1'b0, "R6", "low after power-up edge", clk_out[1], 0);
    mid();
    check(clk_out[1] == 1'b1, "R6", "high one edge later", clk_out[1], 1);
    expect_ratio(1, 8, "R6");

    // R5: shared prescaler, ch1 own code 6 ignored
    write_div(0, 8'b011_00010);                   // 3*2 = 6
    write_div(1, 8'b110_00100);                   // own 6*4, shared 3*4 = 12
    write_sync(1'b1);
    expect_ratio(1, 12, "R5");
    expect_ratio(0, 6, "R5");
    mid();
    p0 = clk_out[0]; p1 = clk_out[1]; rises = 0; miss = 0;
    for (int i = 0; i < 200; i++) begin
      #(HALF);
      if (!p1 && clk_out[1]) begin
        rises++;
        if (!(!p0 && clk_out[0])) miss++;
      end
      p0 = clk_out[0]; p1 = clk_out[1];
    end
    check(rises > 0, "R5", "ch1 rising edges seen", rises, 1);
    check(miss == 0, "R5", "ch1 rises off ch0 rise", miss, 0);

    // R9: writing ch1 under sync restarts ch0 as well
    write_div(1, 8'b110_00100);
    check(clk_out == 2'b00, "R9", "both low after write edge", clk_out, 0);
    mid();
    check(clk_out == 2'b11, "R9", "both high one edge later", clk_out, 3);

    // R5: sync cleared, ch1 back to its own prescaler
    write_sync(1'b0);
    expect_ratio(1, 24, "R5");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule